// File: doc/BRIEF.md
# Power-Gated SRAM Access Controller

This block sits between an asynchronous, SRAM-style host bus and a byte-wide storage array. It decides, one system clock at a time, whether a host cycle may reach the array. The active-low host controls (chip enable, write enable, output enable) and the status flags (supply good, and a low flag for each of two redundant batteries) are brought into the clock domain through two-flop synchronisers. A state machine then turns the synchronised controls into array read and write strobes, an output-driver enable and a write-protect indication.

While the supply is not good the machine sits in `ST_OFF`: no strobe, no driver enable, and the array is write-protected. On each restore of the supply it passes through `ST_CHECK` for one clock, where it evaluates the battery flags. The check fails only when both batteries are flagged low. After a failed check the second host cycle since the restore is swallowed in `ST_BLOCK`. Software can therefore find a dead battery pair by writing a location in that cycle and reading it back. A sticky warning output reports the last check result and keeps it through power loss.

States and transitions: `ST_OFF` goes to `ST_CHECK` when the supply is good. `ST_CHECK` goes to `ST_IDLE` after one clock. `ST_IDLE` goes, when chip enable is low, to `ST_BLOCK` if this is the second cycle and the check failed. Otherwise it goes to `ST_WRITE` if write enable is low, and to `ST_READ` if not. `ST_READ` and `ST_WRITE` move to each other as write enable changes, and return to `ST_IDLE` when chip enable rises. `ST_BLOCK` returns to `ST_IDLE` when chip enable rises. Every state goes to `ST_OFF` when the synchronised supply-good input is low.

Top module: `sram_gate_ctrl`

## Requirements
- R1: With the supply good and the cycle not suppressed, chip enable low with write enable high raises `arr_rd` and keeps `arr_wr` low. The output follows an input change on the third rising clock edge.
- R2: `arr_wr` is high only while chip enable and write enable are both low. It starts at the later of their falling edges and ends at the earlier of their rising edges. If write enable rises while chip enable is still low, the controller returns to a read.
- R3: `drv_en` is high only during a read with output enable low. Write enable falling during an enabled read drops `drv_en`.
- R4: While supply good is low, `arr_rd`, `arr_wr` and `drv_en` are low and `wr_prot` is high, even if it drops in the middle of a cycle.
- R5: The battery flags are evaluated once on each low-to-high transition of supply good. The check fails if and only if both flags are high at that moment.
- R6: A host cycle is one chip-enable-low interval. After a failed check, the second cycle since the restore is suppressed: `arr_rd`, `arr_wr` and `drv_en` stay low. The first and third cycles behave normally.
- R7: With only one battery flagged low, the check passes and the second cycle is a normal access.
- R8: `bat_warn` is set by a failed check and holds through loss of supply. It is cleared by the next check that passes.
- R9: The cycle count clears when supply good drops. After a new restore with a failed check, the second cycle counted from that restore is suppressed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Host chip enable, active low, asynchronous |
| we_n | input | 1 | Host write enable, active low, asynchronous |
| oe_n | input | 1 | Host output enable, active low, asynchronous |
| addr | input | 15 | Host address |
| wdata | input | 8 | Host write data |
| supply_ok | input | 1 | Supply above operating threshold |
| bat_a_low | input | 1 | First battery below low threshold |
| bat_b_low | input | 1 | Second battery below low threshold |
| arr_rd | output | 1 | Array read strobe |
| arr_wr | output | 1 | Array write strobe |
| arr_addr | output | 15 | Address to the array |
| arr_wdata | output | 8 | Write data to the array |
| drv_en | output | 1 | Host data driver enable |
| wr_prot | output | 1 | Array is write-protected |
| bat_warn | output | 1 | Sticky result of the last failed battery check |

## Verification
Two pairs of functions can land in the same cycle. In the first pair, supply good drops while a write is in progress, so the power gate and the write path act together. The bench holds chip enable and write enable low, then removes the supply and judges that the write strobe falls and write protect rises together, while the warning flag keeps its value. In the second pair, a read with the drivers enabled is turned into a write by write enable falling. The bench judges that the driver enable drops in the same clock in which the write strobe rises. Suppression is checked in the same scenarios, once after a failed check and once after a passing one.

// File: rtl/sram_gate_pkg.sv
package sram_gate_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_CHECK,
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_BLOCK
    } acc_state_t;
endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
    parameter int          WIDTH   = 6,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta_q;
        logic sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                sync_q <= RST_VAL[i];
            end else begin
                meta_q <= d_async[i];
                sync_q <= meta_q;
            end
        end
        assign d_sync[i] = sync_q;
    end
endmodule

// File: rtl/sg_cycle_count.sv
module sg_cycle_count #(
    parameter int SAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    output logic is_second
);
    localparam int CW = $clog2(SAT + 1);
    localparam logic [CW-1:0] SAT_V = CW'(SAT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (start && cnt_q != SAT_V) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // a starting cycle is the second one when exactly one has been counted
    assign is_second = (cnt_q == CW'(1));

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == SAT_V && !clr) |=> (cnt_q == SAT_V)); // R6
    AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/sg_bat_check.sv
module sg_bat_check #(
    parameter int NBAT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            eval,
    input  logic [NBAT-1:0] bat_low,
    output logic            chk_fail
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_fail <= 1'b0;
        end else if (eval) begin
            chk_fail <= &bat_low;
        end
    end

    AST_WARN_ONLY_ON_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chk_fail) |-> $past(eval)); // R8
    AST_FAIL_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && !(&bat_low)) |=> !chk_fail); // R7
endmodule

// File: rtl/sram_gate_ctrl.sv
module sram_gate_ctrl
    import sram_gate_pkg::*;
#(
    parameter int AW = 15,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          supply_ok,
    input  logic          bat_a_low,
    input  logic          bat_b_low,
    output logic          arr_rd,
    output logic          arr_wr,
    output logic [AW-1:0] arr_addr,
    output logic [DW-1:0] arr_wdata,
    output logic          drv_en,
    output logic          wr_prot,
    output logic          bat_warn
);
    localparam int NSYNC = 6;
    localparam logic [NSYNC-1:0] SYNC_RST = 6'b111000;

    logic [NSYNC-1:0] sync_v;
    logic ce_s, we_s, oe_s, sok_s, bata_s, batb_s;

    sg_sync #(.WIDTH(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ce_n, we_n, oe_n, supply_ok, bat_a_low, bat_b_low}),
        .d_sync  (sync_v)
    );
    assign {ce_s, we_s, oe_s, sok_s, bata_s, batb_s} = sync_v;

    acc_state_t state_q, state_d;
    logic cyc_start, is_second, chk_fail;

    assign cyc_start = (state_q == ST_IDLE) && sok_s && !ce_s;

    sg_cycle_count #(.SAT(2)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (state_q == ST_OFF),
        .start     (cyc_start),
        .is_second (is_second)
    );

    sg_bat_check #(.NBAT(2)) u_bat (
        .clk      (clk),
        .rst_n    (rst_n),
        .eval     (state_q == ST_CHECK),
        .bat_low  ({bata_s, batb_s}),
        .chk_fail (chk_fail)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!sok_s) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_CHECK;
                ST_CHECK: state_d = ST_IDLE;
                ST_IDLE: begin
                    if (!ce_s) begin
                        if (is_second && chk_fail) state_d = ST_BLOCK;
                        else if (!we_s)            state_d = ST_WRITE;
                        else                       state_d = ST_READ;
                    end
                end
                ST_READ: begin
                    if (ce_s)       state_d = ST_IDLE;
                    else if (!we_s) state_d = ST_WRITE;
                end
                ST_WRITE: begin
                    if (ce_s)      state_d = ST_IDLE;
                    else if (we_s) state_d = ST_READ;
                end
                ST_BLOCK: begin
                    if (ce_s) state_d = ST_IDLE;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        arr_rd  = 1'b0;
        arr_wr  = 1'b0;
        drv_en  = 1'b0;
        wr_prot = 1'b0;
        unique case (state_q)
            ST_OFF, ST_CHECK: wr_prot = 1'b1;
            ST_READ: begin
                arr_rd = 1'b1;
                drv_en = !oe_s;
            end
            ST_WRITE: arr_wr = 1'b1;
            default: ;
        endcase
    end

    assign arr_addr  = addr;
    assign arr_wdata = wdata;
    assign bat_warn  = chk_fail;

    AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_rd && arr_wr)); // R1
    AST_WRITE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_s && !we_s && state_q == ST_WRITE) |=> (arr_wr || ce_s || we_s || !sok_s || !$past(sok_s))); // R2
    AST_DRV_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> (!oe_s && !ce_s || $past(!ce_s))); // R3
    AST_GATE_ON_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        !sok_s |=> (!arr_rd && !arr_wr && !drv_en && wr_prot)); // R4
    AST_BLOCK_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLOCK) |-> chk_fail); // R6
    AST_CHECK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK) |=> (state_q != ST_CHECK)); // R5
endmodule

// File: tb/sram_gate_ctrl_bench.sv
module sram_gate_ctrl_bench;
    typedef struct {
        string      tag;
        logic [4:0] exp;
    } sb_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic supply_ok = 1'b0, bat_a_low = 1'b0, bat_b_low = 1'b0;
    logic arr_rd, arr_wr, drv_en, wr_prot, bat_warn;
    logic [14:0] arr_addr;
    logic [7:0]  arr_wdata;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    sb_item_t sb_q[$];

    always #2 clk = ~clk;

    sram_gate_ctrl u_sram_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .supply_ok(supply_ok),
        .bat_a_low(bat_a_low), .bat_b_low(bat_b_low),
        .arr_rd(arr_rd), .arr_wr(arr_wr), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .drv_en(drv_en), .wr_prot(wr_prot),
        .bat_warn(bat_warn)
    );

    // monitor: {rd, wr, drv, wp, warn}
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            logic [4:0] act;
            it  = sb_q.pop_front();
            act = {arr_rd, arr_wr, drv_en, wr_prot, bat_warn};
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got rd/wr/drv/wp/warn=%b expected %b", it.tag, act, it.exp);
            end
        end
    end

    task automatic settle();
        repeat (4) @(negedge clk);
        #1;
    endtask

    task automatic expect_out(input string tag, input logic [4:0] exp);
        sb_item_t it;
        @(posedge clk);
        it.tag = tag;
        it.exp = exp;
        sb_q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic host(input logic ce, input logic we, input logic oe);
        ce_n = ce; we_n = we; oe_n = oe;
        settle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        expect_out("R4 reset state protected", 5'b00010);

        // restore with both batteries low: check fails
        bat_a_low = 1'b1; bat_b_low = 1'b1;
        supply_ok = 1'b1; settle();
        expect_out("R5 both low sets warning", 5'b00001);
        addr = 15'h1234; wdata = 8'h5A;
        expect_out("R8 warning after fail", 5'b00001);
        if (arr_addr !== 15'h1234 || arr_wdata !== 8'h5A) begin
            n_fail++;
            $display("FAIL R1 address path: got %h/%h expected 1234/5a", arr_addr, arr_wdata);
        end
        n_checks++;
        // cycle 1: read with drivers on, then we falls
        host(1'b0, 1'b1, 1'b0);
        expect_out("R1 first cycle read", 5'b10101);
        host(1'b0, 1'b0, 1'b0);
        expect_out("R3 we fall drops drivers, R2 write", 5'b01001);
        host(1'b1, 1'b1, 1'b1);
        // cycle 2: suppressed
        host(1'b0, 1'b0, 1'b1);
        expect_out("R6 second cycle write suppressed", 5'b00001);
        ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; settle();
        expect_out("R6 second cycle read suppressed", 5'b00001);
        host(1'b1, 1'b1, 1'b1);
        // cycle 3: normal; write starts at later fall (ce)
        host(1'b1, 1'b0, 1'b1);
        expect_out("R2 we alone no write", 5'b00001);
        host(1'b0, 1'b0, 1'b1);
        expect_out("R6 third cycle write, R2 later fall", 5'b01001);
        host(1'b0, 1'b1, 1'b1);
        expect_out("R2 earlier rise ends write", 5'b10001);
        expect_out("R3 oe high no drivers", 5'b10001);
        host(1'b1, 1'b1, 1'b1);
        expect_out("R1 ce high idle", 5'b00001);

        // supply drop in the middle of a write
        host(1'b0, 1'b0, 1'b1);
        expect_out("R2 write before drop", 5'b01001);
        supply_ok = 1'b0; settle();
        expect_out("R4 drop mid write, R8 warn held", 5'b00011);
        host(1'b1, 1'b1, 1'b1);

        // restore with one battery low: passes
        bat_a_low = 1'b1; bat_b_low = 1'b0;
        supply_ok = 1'b1; settle();
        expect_out("R8 pass clears warning", 5'b00000);
        host(1'b0, 1'b1, 1'b0);
        expect_out("R7 first cycle read", 5'b10100);
        host(1'b1, 1'b1, 1'b1);
        host(1'b0, 1'b0, 1'b1);
        expect_out("R7 second cycle write allowed", 5'b01000);
        host(1'b1, 1'b1, 1'b1);

        // drop and restore with both low again: counter restarts
        supply_ok = 1'b0; settle();
        expect_out("R4 supply low", 5'b00010);
        bat_b_low = 1'b1;
        supply_ok = 1'b1; settle();
        expect_out("R5 second restore fails", 5'b00001);
        host(1'b0, 1'b1, 1'b0);
        expect_out("R9 first cycle after restore", 5'b10101);
        host(1'b1, 1'b1, 1'b1);
        host(1'b0, 1'b0, 1'b1);
        expect_out("R9 second cycle suppressed again", 5'b00001);
        host(1'b1, 1'b1, 1'b1);

        // batteries recover while powered: no re-evaluation
        bat_a_low = 1'b0; bat_b_low = 1'b0; settle();
        expect_out("R5 flags ignored between restores", 5'b00001);

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule